// File: doc/BRIEF.md
# Dual-Enable GPIO Pin Bank

This block manages a bank of 32 pins. Each pin is an analog channel, a general-purpose input or a general-purpose output. Two independent enable bits set the pin's role. When the output enable is set, the pin is an output. When only the input enable is set, the pin is an input. When neither is set, the pin stays an analog channel, and the converter front end sees it through the per-pin GPIO indication.

A serial command engine reaches the block through a byte-wide register port with a 4-bit address. There are four groups of byte registers: sampled input state, input enable, output enable and output value. Each group has four byte lanes, and the lanes are numbered in reverse order, so the highest address of a group holds pins 0 to 7. The sampled input state is read-only. It comes through a two-flop synchronizer and is masked by the input enables.

Top module: `pinbank_top`

## Requirements
- R1: After reset, every enable and output-value bit is zero, `pin_oe`, `pin_out` and `pin_is_gpio` are all zero, and `reg_rdata` is zero.
- R2: Address bits [3:2] select the group: 0 is the sampled input state, 1 is the input enable, 2 is the output enable and 3 is the output value. Address bits [1:0] equal to 3, 2, 1 and 0 hold pins 0-7, 8-15, 16-23 and 24-31 respectively. Within a byte, bit k is pin (8·lane + k).
- R3: A write strobe to groups 1 to 3 updates the addressed byte at the clock edge that samples it. A read strobe returns the addressed byte on `reg_rdata` after the edge that samples it. Without a read strobe, `reg_rdata` holds its value.
- R4: Writes to group 0 change no register, no pin output and no read value.
- R5: `pin_oe` equals the output-enable bit of each pin. If both enable bits are set, the pin behaves as an output.
- R6: `pin_out` carries the output-value bit only when the pin's output enable is set, and is 0 otherwise.
- R7: `pin_is_gpio` is 1 when either enable bit of the pin is set, and 0 for a pin with neither set (an analog channel).
- R8: Group 0 reads return the pin input passed through two flops and ANDed with the input enable. A level applied before edge E1 is returned by a read strobe sampled at E1+2 or later. A read strobe sampled at E1+1 still returns the previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address (group, lane) |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Pin output levels, gated by output enable |
| pin_oe | output | 32 | Pin driver enables |
| pin_is_gpio | output | 32 | Per-pin GPIO indication for the converter status flag |

## Verification
The hardest situation to reach from the ports is the exact latency edge of the input synchronizer. The bench changes `pin_in` on a falling edge, lets one rising edge pass, and then reads the same byte twice back to back. The first read must still return the old level and the second must return the new one. The bench also sweeps every writable register with arithmetic patterns, so that all four enable combinations, including both enables set, occur on every pin against a bench-side model of the reversed lane map.

// File: rtl/pinbank_pkg.sv
// Shared definitions for the pin bank: register group codes.
package pinbank_pkg;
    // Group selected by the two upper address bits.
    typedef enum logic [1:0] {
        GRP_IN_VAL  = 2'd0,
        GRP_IN_EN   = 2'd1,
        GRP_OUT_EN  = 2'd2,
        GRP_OUT_VAL = 2'd3
    } grp_e;
endpackage

// File: rtl/pinbank_sync.sv
// Two-flop synchronizer for the asynchronous pin inputs.
// Assumes each bit is independent (no bus coherency needed).
module pinbank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Capture then re-time the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/pinbank_regs.sv
// Per-lane storage for input enable, output enable and output value.
// Assumes wr_lane is already the physical lane (reverse decode done above).
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int LANE_W   = 8,
    localparam int NUM_LANES = NUM_PINS / LANE_W,
    localparam int LSW       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  grp_e                wr_grp,
    input  logic [LSW-1:0]      wr_lane,
    input  logic [LANE_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] in_en,
    output logic [NUM_PINS-1:0] out_en,
    output logic [NUM_PINS-1:0] out_val
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] ie_q;
        logic [LANE_W-1:0] oe_q;
        logic [LANE_W-1:0] ov_q;
        logic              hit;

        assign hit = wr_en && (wr_lane == LSW'(l));

        // Load the byte of the addressed group; the input-state group is not stored.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ie_q <= '0;
                oe_q <= '0;
                ov_q <= '0;
            end else if (hit) begin
                case (wr_grp)
                    GRP_IN_EN:   ie_q <= wr_data;
                    GRP_OUT_EN:  oe_q <= wr_data;
                    GRP_OUT_VAL: ov_q <= wr_data;
                    default:     ;
                endcase
            end
        end

        assign in_en  [l*LANE_W +: LANE_W] = ie_q;
        assign out_en [l*LANE_W +: LANE_W] = oe_q;
        assign out_val[l*LANE_W +: LANE_W] = ov_q;
    end

    // R1: enables are clear in the first cycle after reset.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (in_en == '0 && out_en == '0 && out_val == '0))
        else $error("p_reset_clear_r1");
endmodule

// File: rtl/pinbank_readmux.sv
// Registered read path: picks a byte of one group and holds it until the next strobe.
// Input-state bytes are masked by the input enables here.
module pinbank_readmux
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int LANE_W   = 8,
    localparam int NUM_LANES = NUM_PINS / LANE_W,
    localparam int LSW       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  grp_e                rd_grp,
    input  logic [LSW-1:0]      rd_lane,
    input  logic [NUM_PINS-1:0] in_sync,
    input  logic [NUM_PINS-1:0] in_en,
    input  logic [NUM_PINS-1:0] out_en,
    input  logic [NUM_PINS-1:0] out_val,
    output logic [LANE_W-1:0]   rdata
);
    logic [LANE_W-1:0] sel_byte;
    logic [LANE_W-1:0] rdata_q;

    // Select the addressed byte of the addressed group.
    always_comb begin
        case (rd_grp)
            GRP_IN_VAL:  sel_byte = in_sync[rd_lane*LANE_W +: LANE_W]
                                  & in_en[rd_lane*LANE_W +: LANE_W];
            GRP_IN_EN:   sel_byte = in_en  [rd_lane*LANE_W +: LANE_W];
            GRP_OUT_EN:  sel_byte = out_en [rd_lane*LANE_W +: LANE_W];
            default:     sel_byte = out_val[rd_lane*LANE_W +: LANE_W];
        endcase
    end

    // Latch the selected byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= sel_byte;
    end

    assign rdata = rdata_q;

    // R3: read data holds without a strobe.
    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata))
        else $error("p_rdata_hold_r3");

    // R8: input-state read of a lane with no input enables returns zero.
    p_in_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_grp == GRP_IN_VAL && in_en[rd_lane*LANE_W +: LANE_W] == '0)
        |=> rdata == '0)
        else $error("p_in_masked_r8");
endmodule

// File: rtl/pinbank_top.sv
// Dual-enable GPIO pin bank: byte register port, pin drivers and GPIO indication.
// Assumes NUM_PINS is a multiple of LANE_W; lanes are addressed in reverse.
module pinbank_top
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int LANE_W   = 8,
    localparam int NUM_LANES = NUM_PINS / LANE_W,
    localparam int LSW       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int ADDR_W    = LSW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [LANE_W-1:0]   reg_wdata,
    input  logic                reg_rd_en,
    output logic [LANE_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_is_gpio
);
    localparam logic [LSW-1:0] LAST_LANE = LSW'(NUM_LANES - 1);

    grp_e                grp;
    logic [LSW-1:0]      lane_idx;
    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_PINS-1:0] in_en;
    logic [NUM_PINS-1:0] out_en;
    logic [NUM_PINS-1:0] out_val;

    // Decode group and reversed lane from the address.
    assign grp      = grp_e'(reg_addr[ADDR_W-1 -: 2]);
    assign lane_idx = LAST_LANE - reg_addr[LSW-1:0];

    pinbank_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    pinbank_regs #(.NUM_PINS(NUM_PINS), .LANE_W(LANE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_grp  (grp),
        .wr_lane (lane_idx),
        .wr_data (reg_wdata),
        .in_en   (in_en),
        .out_en  (out_en),
        .out_val (out_val)
    );

    pinbank_readmux #(.NUM_PINS(NUM_PINS), .LANE_W(LANE_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (reg_rd_en),
        .rd_grp  (grp),
        .rd_lane (lane_idx),
        .in_sync (in_sync),
        .in_en   (in_en),
        .out_en  (out_en),
        .out_val (out_val),
        .rdata   (reg_rdata)
    );

    // Pin roles: output enable wins, either enable marks a GPIO.
    assign pin_oe      = out_en;
    assign pin_out     = out_val & out_en;
    assign pin_is_gpio = out_en | in_en;

    // R3: an output-enable write lands in the decoded lane.
    p_wr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && grp == GRP_OUT_EN)
        |=> pin_oe[$past(lane_idx)*LANE_W +: LANE_W] == $past(reg_wdata))
        else $error("p_wr_lands_r3");

    // R4: writes to the input-state group leave every pin output alone.
    p_in_grp_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && grp == GRP_IN_VAL)
        |=> ($stable(pin_oe) && $stable(pin_out) && $stable(pin_is_gpio)))
        else $error("p_in_grp_ro_r4");

    // R6: no pin carries a high output level while its driver is off.
    p_out_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0)
        else $error("p_out_gated_r6");

    // R7: every driven pin is reported as a GPIO.
    p_oe_is_gpio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~pin_is_gpio) == '0)
        else $error("p_oe_is_gpio_r7");
endmodule

// File: tb/pinbank_top_test.sv
// Self-checking bench: register sweeps against an arithmetic model.
module pinbank_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] pin_is_gpio;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] ie_m = '0;
    logic [31:0] oe_m = '0;
    logic [31:0] ov_m = '0;

    always #2 clk = ~clk;

    pinbank_top uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_is_gpio(pin_is_gpio)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int lane_of(input logic [3:0] a);
        return 3 - int'(a[1:0]);
    endfunction

    // Expected byte for an address, with the pin input assumed settled.
    function automatic logic [7:0] exp_byte(input logic [3:0] a);
        logic [31:0] v;
        case (a[3:2])
            2'd0:    v = pin_in & ie_m;
            2'd1:    v = ie_m;
            2'd2:    v = oe_m;
            default: v = ov_m;
        endcase
        return v[lane_of(a)*8 +: 8];
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (a[3:2])
            2'd1: ie_m[lane_of(a)*8 +: 8] = d;
            2'd2: oe_m[lane_of(a)*8 +: 8] = d;
            2'd3: ov_m[lane_of(a)*8 +: 8] = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic check_pins(input string tag);
        check({tag, " R5 pin_oe"}, pin_oe, oe_m);
        check({tag, " R6 pin_out"}, pin_out, ov_m & oe_m);
        check({tag, " R7 pin_is_gpio"}, pin_is_gpio, ie_m | oe_m);
    endtask

    task automatic check_all_reads(input string tag);
        logic [7:0] d;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check({tag, " R2 R3 readback"}, {24'h0, d}, {24'h0, exp_byte(4'(a))});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports
        check("R1 rdata", {24'h0, reg_rdata}, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_is_gpio", pin_is_gpio, 32'h0);
        pin_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check_all_reads("R1 all zero");

        // R2: reversed lane mapping, single bits
        wr(4'h8, 8'h01);
        check("R2 addr8 bit0 -> pin24", pin_oe, 32'h0100_0000);
        wr(4'h8, 8'h00);
        wr(4'hB, 8'h80);
        check("R2 addrB bit7 -> pin7", pin_oe, 32'h0000_0080);
        wr(4'h6, 8'h02);
        check("R2 addr6 bit1 -> pin9 gpio", pin_is_gpio, 32'h0000_0280);
        wr(4'hF, 8'hFF);
        check("R6 only pin7 driven", pin_out, 32'h0000_0080);

        // R5: both enables set on lane of pins 0-7, output wins
        wr(4'h7, 8'hFF);
        wr(4'hB, 8'h0F);
        wr(4'hF, 8'h5A);
        check("R5 both enables oe", pin_oe, 32'h0000_000F);
        check("R6 both enables out", pin_out, 32'h0000_000A);
        check("R7 both enables gpio", pin_is_gpio, 32'h0000_02FF);
        check_pins("R5 corner");

        // R4: writes to input-state group are ignored
        for (int a = 0; a < 4; a++) wr(4'(a), 8'hC3);
        check_pins("R4 after ro write");
        check_all_reads("R4 after ro write");

        // R8: synchronizer latency and masking
        wr(4'h7, 8'hFF);
        pin_in = 32'h0;
        repeat (3) @(negedge clk);
        rd(4'h3, d);
        check("R8 settled low", {24'h0, d}, 32'h0);
        pin_in = 32'h0000_00A5;
        @(negedge clk);
        rd(4'h3, d);
        check("R8 read at E1+1 still old", {24'h0, d}, 32'h0);
        rd(4'h3, d);
        check("R8 read at E1+2 new", {24'h0, d}, 32'hA5);
        wr(4'h7, 8'h0F);
        rd(4'h3, d);
        check("R8 masked by input enable", {24'h0, d}, 32'h05);
        rd(4'h0, d);
        check("R8 no enable lane reads zero", {24'h0, d}, 32'h0);
        // R3: rdata holds without strobe
        @(negedge clk);
        check("R3 rdata hold", {24'h0, reg_rdata}, 32'h0);

        // Sweep: arithmetic patterns over all writable registers
        for (int it = 0; it < 40; it++) begin
            pin_in = 32'(it * 32'h9E37_79B9 + 32'h1234_5677);
            for (int a = 4; a < 16; a++)
                wr(4'(a), 8'((it * 37 + a * 91 + 13) ^ (it << 3)));
            check_pins("sweep");
            check_all_reads("sweep R8");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule